// File: doc/BRIEF.md
# Banked Interrupt Control Unit

This block collects level-sensitive interrupt lines in several identical banks of 32 sources each. Each bank latches its sources into a pending register. An enable register gates the pending bits into a masked view, and the bank raises one request line toward the processor whenever any enabled source is pending.

Software reaches every bank through a plain 32-bit register bus with a fixed address stride. Reads are combinational and writes take effect at the clock edge. Software acknowledges a source by writing a one to its pending bit. It can also inject a source through the resend register.

Top module: `banked_irq_ctrl`

## Requirements
- R1: After reset, every bank's enable, pending and resend registers are zero, its latch-mask register is all ones, and all request outputs are low.
- R2: Bank n starts at byte address n*0x28. Its registers sit at these offsets: 0x00 pending, 0x08 enable, 0x10 masked view, 0x18 resend, 0x20 latch mask. Any other address reads as zero, and writes to it change no register.
- R3: The masked view reads as pending AND enable. Request output n is high exactly when bank n's masked view is non-zero.
- R4: Writing the pending register clears each bit written as 1 and leaves each bit written as 0 unchanged. A pending bit never drops without such a write.
- R5: A source that is high at a clock edge, with its latch-mask bit at 1, is pending after that edge. This holds even when the same edge carries a clear of that bit, because the level wins.
- R6: A source whose latch-mask bit is 0 does not set its pending bit.
- R7: A bit set in the resend register makes the matching pending bit set from the edge that writes it, and it keeps that bit set for as long as the resend bit stays at 1.
- R8: The masked view is read-only. Writing it leaves enable, latch mask, resend and pending unchanged.
- R9: Software initialisation deasserts every request output. Initialisation means writing enable 0, pending all ones, latch mask all ones and resend 0 to each bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_src | input | NUM_BANKS*SRC_W | Level sources, bank n in bits [n*SRC_W +: SRC_W] |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | SRC_W | Write data |
| bus_rdata | output | SRC_W | Combinational read data |
| cpu_req | output | NUM_BANKS | One request line per bank |

## Verification
The bench targets the collision of a clear write with a source that is still high. A design where the clear wins would lose that interrupt, and the bench would read a zero pending bit. It also writes the read-only masked view and unaligned or out-of-range addresses. A loose decoder would alias those writes onto the enable register, and the bench would see enable change. Resend is tested by acknowledging while the resend bit is still set: a design that treats resend as a one-shot pulse would show the bit cleared. The last test runs the initialisation sequence on a bank that has pending sources and expects every request line to fall.

// File: rtl/banked_irq_pkg.sv
package banked_irq_pkg;
    localparam int BANK_STRIDE = 40;
    localparam int OFF_PEND    = 0;
    localparam int OFF_EN      = 8;
    localparam int OFF_VIEW    = 16;
    localparam int OFF_RESEND  = 24;
    localparam int OFF_LMASK   = 32;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_PEND,
        SEL_EN,
        SEL_VIEW,
        SEL_RESEND,
        SEL_LMASK
    } reg_sel_e;
endpackage

// File: rtl/irq_addr_dec.sv
module irq_addr_dec
    import banked_irq_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int ADDR_W    = 8
) (
    input  logic [ADDR_W-1:0]    addr,
    output logic [NUM_BANKS-1:0] bank_hit,
    output reg_sel_e             reg_sel
);
    localparam logic [ADDR_W-1:0] STRIDE_V = ADDR_W'(BANK_STRIDE);

    logic [ADDR_W-1:0] rel [NUM_BANKS];

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        localparam logic [ADDR_W-1:0] BASE_V = ADDR_W'(b * BANK_STRIDE);
        assign rel[b]      = addr - BASE_V;
        assign bank_hit[b] = (addr >= BASE_V) && (rel[b] < STRIDE_V);
    end

    always_comb begin
        reg_sel = SEL_NONE;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (bank_hit[b]) begin
                if      (rel[b] == ADDR_W'(OFF_PEND))   reg_sel = SEL_PEND;
                else if (rel[b] == ADDR_W'(OFF_EN))     reg_sel = SEL_EN;
                else if (rel[b] == ADDR_W'(OFF_VIEW))   reg_sel = SEL_VIEW;
                else if (rel[b] == ADDR_W'(OFF_RESEND)) reg_sel = SEL_RESEND;
                else if (rel[b] == ADDR_W'(OFF_LMASK))  reg_sel = SEL_LMASK;
            end
        end
    end
endmodule

// File: rtl/irq_bank.sv
module irq_bank
    import banked_irq_pkg::*;
#(
    parameter int SRC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC_W-1:0] src,
    input  logic             we,
    input  reg_sel_e         sel,
    input  logic [SRC_W-1:0] wdata,
    output logic [SRC_W-1:0] rdata,
    output logic             req
);
    typedef struct packed {
        logic [SRC_W-1:0] pend;
        logic [SRC_W-1:0] en;
        logic [SRC_W-1:0] resend;
        logic [SRC_W-1:0] lmask;
    } bank_st_t;

    bank_st_t st_d, st_q;
    logic [SRC_W-1:0] clr_vec_d;
    logic [SRC_W-1:0] view_d;

    always_comb begin
        st_d      = st_q;
        clr_vec_d = '0;
        if (we) begin
            unique case (sel)
                SEL_PEND:   clr_vec_d   = wdata;
                SEL_EN:     st_d.en     = wdata;
                SEL_RESEND: st_d.resend = wdata;
                SEL_LMASK:  st_d.lmask  = wdata;
                default:    ;
            endcase
        end
        st_d.pend = (st_q.pend & ~clr_vec_d) | (src & st_q.lmask) | st_d.resend;
        view_d    = st_q.pend & st_q.en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.pend   <= '0;
            st_q.en     <= '0;
            st_q.resend <= '0;
            st_q.lmask  <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        unique case (sel)
            SEL_PEND:   rdata = st_q.pend;
            SEL_EN:     rdata = st_q.en;
            SEL_VIEW:   rdata = view_d;
            SEL_RESEND: rdata = st_q.resend;
            SEL_LMASK:  rdata = st_q.lmask;
            default:    rdata = '0;
        endcase
    end

    assign req = |view_d;

    assert_level_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((st_q.pend & $past(src & st_q.lmask)) == $past(src & st_q.lmask)));

    assert_pend_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(st_q.pend) & ~st_q.pend) & ~$past(clr_vec_d)) == '0));

    assert_resend_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.pend & st_q.resend) == st_q.resend));

    assert_view_readonly_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (we && sel == SEL_VIEW) |=> ($stable(st_q.en) && $stable(st_q.lmask) && $stable(st_q.resend)));

    assert_enable_gates_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.en == '0) |-> !req);
endmodule

// File: rtl/banked_irq_ctrl.sv
module banked_irq_ctrl
    import banked_irq_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int SRC_W     = 32,
    parameter int ADDR_W    = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_BANKS*SRC_W-1:0] irq_src,
    input  logic                       bus_we,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic [SRC_W-1:0]           bus_wdata,
    output logic [SRC_W-1:0]           bus_rdata,
    output logic [NUM_BANKS-1:0]       cpu_req
);
    logic [NUM_BANKS-1:0] bank_hit;
    reg_sel_e             reg_sel;
    logic [SRC_W-1:0]     bank_rdata [NUM_BANKS];

    irq_addr_dec #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W)) u_dec (
        .addr     (bus_addr),
        .bank_hit (bank_hit),
        .reg_sel  (reg_sel)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        irq_bank #(.SRC_W(SRC_W)) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .src   (irq_src[b*SRC_W +: SRC_W]),
            .we    (bus_we && bank_hit[b]),
            .sel   (reg_sel),
            .wdata (bus_wdata),
            .rdata (bank_rdata[b]),
            .req   (cpu_req[b])
        );
    end

    always_comb begin
        bus_rdata = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (bank_hit[b]) bus_rdata = bus_rdata | bank_rdata[b];
        end
    end

    assert_one_bank_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bank_hit));

    assert_unmapped_reads_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel == SEL_NONE) |-> (bus_rdata == '0));
endmodule

// File: tb/banked_irq_ctrl_tb.sv
`timescale 1ns/1ps
module banked_irq_ctrl_tb;
    localparam int NB = 4;
    localparam int SW = 32;
    localparam int AW = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NB*SW-1:0]  irq_src = '0;
    logic              bus_we = 1'b0;
    logic [AW-1:0]     bus_addr = '0;
    logic [SW-1:0]     bus_wdata = '0;
    logic [SW-1:0]     bus_rdata;
    logic [NB-1:0]     cpu_req;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    banked_irq_ctrl #(.NUM_BANKS(NB), .SRC_W(SW), .ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .irq_src(irq_src), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cpu_req(cpu_req)
    );

    typedef struct packed {
        logic          we;
        logic [7:0]    addr;
        logic [31:0]   wdata;
        logic [31:0]   src;
        logic [7:0]    rd_addr;
        logic [31:0]   exp_rd;
        logic          exp_req;
    } vec_t;

    // Bank 0 walk: offsets 00 pend, 08 enable, 10 view, 18 resend, 20 latch mask
    localparam vec_t VECS [17] = '{
        '{1'b1, 8'h08, 32'h0000_00FF, 32'h0,     8'h08, 32'h0000_00FF, 1'b0}, // R2 enable write
        '{1'b0, 8'h00, 32'h0,         32'h11,    8'h00, 32'h0000_0011, 1'b1}, // R5 latch, R3 req
        '{1'b1, 8'h00, 32'h0000_0001, 32'h0,     8'h00, 32'h0000_0010, 1'b1}, // R4 partial clear
        '{1'b1, 8'h00, 32'h0000_0010, 32'h10,    8'h00, 32'h0000_0010, 1'b1}, // R5 level wins
        '{1'b1, 8'h00, 32'h0000_0010, 32'h0,     8'h00, 32'h0,         1'b0}, // R4 clear
        '{1'b0, 8'h00, 32'h0,         32'h100,   8'h00, 32'h0000_0100, 1'b0}, // R3 disabled source
        '{1'b0, 8'h00, 32'h0,         32'h0,     8'h10, 32'h0,         1'b0}, // R3 view gated
        '{1'b1, 8'h08, 32'h0000_0100, 32'h0,     8'h10, 32'h0000_0100, 1'b1}, // R3 view open
        '{1'b1, 8'h10, 32'hFFFF_FFFF, 32'h0,     8'h08, 32'h0000_0100, 1'b1}, // R8 view read-only
        '{1'b1, 8'h00, 32'hFFFF_FFFF, 32'h0,     8'h00, 32'h0,         1'b0}, // R4 clear all
        '{1'b1, 8'h20, 32'hFFFF_FEFF, 32'h0,     8'h20, 32'hFFFF_FEFF, 1'b0}, // R6 mask write
        '{1'b0, 8'h00, 32'h0,         32'h100,   8'h00, 32'h0,         1'b0}, // R6 masked source
        '{1'b1, 8'h20, 32'hFFFF_FFFF, 32'h0,     8'h20, 32'hFFFF_FFFF, 1'b0}, // R6 mask restore
        '{1'b1, 8'h18, 32'h0000_0100, 32'h0,     8'h00, 32'h0000_0100, 1'b1}, // R7 inject
        '{1'b1, 8'h00, 32'h0000_0100, 32'h0,     8'h00, 32'h0000_0100, 1'b1}, // R7 held by resend
        '{1'b1, 8'h18, 32'h0,         32'h0,     8'h18, 32'h0,         1'b1}, // R7 resend off
        '{1'b1, 8'h00, 32'h0000_0100, 32'h0,     8'h00, 32'h0,         1'b0}  // R4 final ack
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_we = 1'b0;
        @(negedge clk);
    endtask

    task automatic rd_check(input string tag, input logic [7:0] a, input logic [31:0] exp);
        bus_addr = a; #1;
        check(tag, bus_rdata, exp);
    endtask

    task automatic idle_cycle();
        @(posedge clk); #1;
        @(negedge clk);
    endtask

    initial begin
        #1_000_000;
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 req", {28'h0, cpu_req}, 32'h0);
        rd_check("R1 pend", 8'h00, 32'h0);
        rd_check("R1 enable", 8'h08, 32'h0);
        rd_check("R1 resend", 8'h18, 32'h0);
        rd_check("R1 lmask bank1", 8'h48, 32'hFFFF_FFFF);

        for (int i = 0; i < 17; i++) begin
            bus_we = VECS[i].we; bus_addr = VECS[i].addr;
            bus_wdata = VECS[i].wdata; irq_src[31:0] = VECS[i].src;
            @(posedge clk); #1;
            bus_we = 1'b0;
            #2;
            rd_check($sformatf("vector %0d R2-map rd", i), VECS[i].rd_addr, VECS[i].exp_rd);
            check($sformatf("vector %0d R3 req0", i), {31'h0, cpu_req[0]}, {31'h0, VECS[i].exp_req});
            @(negedge clk);
        end
        irq_src = '0;

        // R2 bank 1 at 0x28
        wr(8'h30, 32'h1);
        irq_src[32] = 1'b1;
        idle_cycle();
        irq_src[32] = 1'b0;
        rd_check("R2 bank1 pend", 8'h28, 32'h1);
        check("R3 bank1 req only", {28'h0, cpu_req}, 32'h2);
        wr(8'h28, 32'h1);
        check("R4 bank1 ack", {28'h0, cpu_req}, 32'h0);

        // R2 unmapped and unaligned
        rd_check("R2 out of range", 8'hA0, 32'h0);
        rd_check("R2 unaligned", 8'h04, 32'h0);
        wr(8'h0C, 32'hFFFF_FFFF);
        rd_check("R2 unaligned write ignored", 8'h08, 32'h0000_0100);

        // R9 init sequence on bank 2 with injected pending
        wr(8'h68, 32'h0000_00F0);
        wr(8'h58, 32'h0000_00FF);
        check("R7 bank2 req", {28'h0, cpu_req}, 32'h4);
        for (int b = 0; b < NB; b++) begin
            wr(8'(b * 40 + 8),  32'h0);
            wr(8'(b * 40),      32'hFFFF_FFFF);
            wr(8'(b * 40 + 32), 32'hFFFF_FFFF);
            wr(8'(b * 40 + 24), 32'h0);
        end
        check("R9 all req low", {28'h0, cpu_req}, 32'h0);
        rd_check("R9 bank2 view", 8'h60, 32'h0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule